// File: doc/BRIEF.md
# Masked Timing Event Capture

This block takes timing event codes that some other logic has already decoded. Each code is 8 bits wide and is qualified by a strobe that lasts one cycle. The incoming code is used directly as the index into a 256-entry table of one-bit enables. When the indexed enable is set, the code is queued in an event FIFO. An interrupt request then stays asserted toward the processor for as long as any queued code remains unread. The request carries the fixed vector number 0x16.

The host sees one word-oriented register space. Mask entries sit on word boundaries, so the host address of the entry for a code is that code shifted left by one. Address bit 9 set selects the control region, where the FIFO head and a sticky overflow flag can be read.

Queue occupancy is tracked by a state machine with three states:

- **Q_EMPTY**: nothing queued, interrupt low.
- **Q_PART**: some entries queued, interrupt high.
- **Q_FULL**: every slot in use. An enabled event that arrives now is dropped, and the overflow flag is set.

The transitions are:

- **Q_EMPTY to Q_PART**: an accepted push.
- **Q_PART to Q_EMPTY**: the last entry is popped with no push in the same cycle.
- **Q_PART to Q_FULL**: the last free slot is filled with no pop in the same cycle.
- **Q_FULL to Q_PART**: any pop.

Top module: `evt_capture`

## Requirements
- R1: After reset the interrupt is low and every mask entry reads 0. The status word and a FIFO read both return 0. The vector output is always 0x16.
- R2: A host write with address bit 9 = 0 sets the mask entry for code = address bits 8..1 to write-data bit 0; the other data bits are ignored. A host read returns the value on the data output in the cycle after the read strobe. For a mask read that value is {15'b0, enable}.
- R3: An event whose mask bit is 0 is not queued. The interrupt does not rise for it, and a later FIFO read does not return it.
- R4: An event whose mask bit is 1 is queued. Reading address 0x200 pops the oldest entry and returns {8'h00, code}, in arrival order.
- R5: The interrupt rises in the cycle after the strobe of the first accepted event. It stays high while any entry is unread, and it falls in the cycle after the pop of the last entry.
- R6: A FIFO read while the queue is empty returns 0. It changes neither the interrupt nor the overflow flag.
- R7: An enabled event that arrives while the queue holds DEPTH entries (16 by default) is dropped, even if a pop happens in the same cycle. The drop sets the overflow flag, and the queued entries are unchanged.
- R8: The overflow flag is bit 0 of the status word at address 0x202. It stays set until the host writes 0x202 with data bit 0 = 1. A write there with data bit 0 = 0 leaves it set.
- R9: When a mask write and an event strobe occur in the same cycle, the event is judged against the mask value from before the write.
- R10: When the queue is not full, an event push and a FIFO pop in the same cycle both take effect. The pop returns the entry that was at the head before the push, or 0 if the queue was empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_strobe_i | input | 1 | One-cycle qualifier for evt_code_i |
| evt_code_i | input | 8 | Decoded event code |
| host_wr_i | input | 1 | Host write strobe |
| host_rd_i | input | 1 | Host read strobe |
| host_addr_i | input | 10 | Host word address |
| host_wdata_i | input | 16 | Host write data |
| host_rdata_o | output | 16 | Host read data, valid the cycle after host_rd_i |
| irq_o | output | 1 | Level interrupt request, high while entries are queued |
| irq_vec_o | output | 8 | Interrupt vector number (0x16) |

## Verification
The hardest situations to reach from the ports are the collisions that happen within a single cycle. These are a push that coincides with a pop, and a mask write that coincides with an event for the same code. The stimulus drives both inputs inside one clocked step. The expected result is judged from the model's state before that step.

The overflow path is reached by enabling sixteen distinct codes and queuing all of them. One more event is then sent into the full queue. The run then checks that the drop left all sixteen entries intact and in order.

// File: rtl/evt_cap_pkg.sv
package evt_cap_pkg;

    typedef enum logic [1:0] {
        SEL_MASK,
        SEL_FIFO,
        SEL_STAT
    } host_sel_e;

    typedef enum logic [1:0] {
        Q_EMPTY,
        Q_PART,
        Q_FULL
    } q_state_e;

    // Address bit AW-1 selects the control region; bit 1 picks status over FIFO.
    function automatic host_sel_e decode_sel(input logic top_bit, input logic bit1);
        if (!top_bit)
            return SEL_MASK;
        else if (bit1)
            return SEL_STAT;
        else
            return SEL_FIFO;
    endfunction

endpackage

// File: rtl/evt_mask_mem.sv
module evt_mask_mem #(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] lk_code,
    output logic              lk_en,
    input  logic              wr_en,
    input  logic [CODE_W-1:0] wr_code,
    input  logic              wr_bit,
    input  logic [CODE_W-1:0] rd_code,
    output logic              rd_bit
);
    localparam int NUM = 1 << CODE_W;

    logic [NUM-1:0] en_bits;

    always_ff @(posedge clk) begin
        if (!rst_n)
            en_bits <= '0;
        else if (wr_en)
            en_bits[wr_code] <= wr_bit;
    end

    // Lookups see the stored value, i.e. the one before a write in this cycle.
    assign lk_en  = en_bits[lk_code];
    assign rd_bit = en_bits[rd_code];

endmodule

// File: rtl/evt_queue.sv
module evt_queue #(
    parameter int DW    = 8,
    parameter int DEPTH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] head
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [DW-1:0] slots [DEPTH];
    logic [AW-1:0] wptr;
    logic [AW-1:0] rptr;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == LAST) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (push)
                wptr <= bump(wptr);
            if (pop)
                rptr <= bump(rptr);
        end
    end

    always_ff @(posedge clk) begin
        if (push)
            slots[wptr] <= din;
    end

    assign head = slots[rptr];

endmodule

// File: rtl/evt_queue_ctrl.sv
module evt_queue_ctrl
    import evt_cap_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push_req,
    input  logic pop_req,
    output logic push_ok,
    output logic pop_ok,
    output logic drop,
    output logic empty,
    output logic full
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] ONE      = CW'(1);
    localparam logic [CW-1:0] NEAR_TOP = CW'(DEPTH - 1);

    q_state_e      state, state_nx;
    logic [CW-1:0] count, count_nx;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= Q_EMPTY;
            count <= '0;
        end else begin
            state <= state_nx;
            count <= count_nx;
        end
    end

    // Outputs
    always_comb begin
        push_ok = 1'b0;
        pop_ok  = 1'b0;
        drop    = 1'b0;
        empty   = 1'b0;
        full    = 1'b0;
        unique case (state)
            Q_EMPTY: begin
                empty   = 1'b1;
                push_ok = push_req;
            end
            Q_PART: begin
                push_ok = push_req;
                pop_ok  = pop_req;
            end
            Q_FULL: begin
                full   = 1'b1;
                drop   = push_req;
                pop_ok = pop_req;
            end
            default: begin
                empty = 1'b1;
            end
        endcase
    end

    // Next state
    always_comb begin
        state_nx = state;
        count_nx = count;
        if (push_ok && !pop_ok)
            count_nx = count + ONE;
        else if (pop_ok && !push_ok)
            count_nx = count - ONE;
        unique case (state)
            Q_EMPTY: if (push_ok) state_nx = Q_PART;
            Q_PART: begin
                if (pop_ok && !push_ok && count == ONE)
                    state_nx = Q_EMPTY;
                else if (push_ok && !pop_ok && count == NEAR_TOP)
                    state_nx = Q_FULL;
            end
            Q_FULL: if (pop_ok) state_nx = (DEPTH == 1) ? Q_EMPTY : Q_PART;
            default: state_nx = Q_EMPTY;
        endcase
    end

endmodule

// File: rtl/evt_capture.sv
module evt_capture
    import evt_cap_pkg::*;
#(
    parameter int          CODE_W  = 8,
    parameter int          DEPTH   = 16,
    parameter int          DATA_W  = 16,
    parameter logic [7:0]  IRQ_VEC = 8'h16,
    localparam int         ADDR_W  = CODE_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_strobe_i,
    input  logic [CODE_W-1:0] evt_code_i,
    input  logic              host_wr_i,
    input  logic              host_rd_i,
    input  logic [ADDR_W-1:0] host_addr_i,
    input  logic [DATA_W-1:0] host_wdata_i,
    output logic [DATA_W-1:0] host_rdata_o,
    output logic              irq_o,
    output logic [7:0]        irq_vec_o
);
    host_sel_e         sel;
    logic [CODE_W-1:0] host_code;
    logic              lk_en;
    logic              mask_rd_bit;
    logic              evt_hit;
    logic              fifo_rd;
    logic              push_ok, pop_ok, drop, q_empty, q_full;
    logic [CODE_W-1:0] q_head;
    logic              ovf_q;
    logic              ovf_clr;

    assign sel       = decode_sel(host_addr_i[ADDR_W-1], host_addr_i[1]);
    assign host_code = host_addr_i[CODE_W:1];

    evt_mask_mem #(.CODE_W(CODE_W)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .lk_code (evt_code_i),
        .lk_en   (lk_en),
        .wr_en   (host_wr_i && sel == SEL_MASK),
        .wr_code (host_code),
        .wr_bit  (host_wdata_i[0]),
        .rd_code (host_code),
        .rd_bit  (mask_rd_bit)
    );

    assign evt_hit = evt_strobe_i && lk_en;
    assign fifo_rd = host_rd_i && sel == SEL_FIFO;

    evt_queue_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_req (evt_hit),
        .pop_req  (fifo_rd),
        .push_ok  (push_ok),
        .pop_ok   (pop_ok),
        .drop     (drop),
        .empty    (q_empty),
        .full     (q_full)
    );

    evt_queue #(.DW(CODE_W), .DEPTH(DEPTH)) u_queue (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push_ok),
        .din   (evt_code_i),
        .pop   (pop_ok),
        .head  (q_head)
    );

    assign ovf_clr = host_wr_i && sel == SEL_STAT && host_wdata_i[0];

    always_ff @(posedge clk) begin
        if (!rst_n)
            ovf_q <= 1'b0;
        else if (drop)
            ovf_q <= 1'b1;
        else if (ovf_clr)
            ovf_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rdata_o <= '0;
        end else if (host_rd_i) begin
            unique case (sel)
                SEL_MASK: host_rdata_o <= DATA_W'(mask_rd_bit);
                SEL_FIFO: host_rdata_o <= q_empty ? '0 : DATA_W'(q_head);
                SEL_STAT: host_rdata_o <= DATA_W'(ovf_q);
                default:  host_rdata_o <= '0;
            endcase
        end
    end

    assign irq_o     = !q_empty;
    assign irq_vec_o = IRQ_VEC;

endmodule

// File: rtl/evt_capture_chk.sv
module evt_capture_chk #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              evt_strobe_i,
    input logic              host_wr_i,
    input logic              host_rd_i,
    input logic [ADDR_W-1:0] host_addr_i,
    input logic [DATA_W-1:0] host_wdata_i,
    input logic [DATA_W-1:0] host_rdata_o,
    input logic              irq_o,
    input logic              evt_hit,
    input logic              q_full,
    input logic              ovf_q
);
    logic fifo_sel, stat_sel;
    assign fifo_sel = host_addr_i[ADDR_W-1] && !host_addr_i[1];
    assign stat_sel = host_addr_i[ADDR_W-1] && host_addr_i[1];

    // R6
    empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd_i && fifo_sel && !irq_o |=> host_rdata_o == '0);

    // R7
    drop_sets_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_hit && q_full |=> ovf_q);

    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q && !(host_wr_i && stat_sel && host_wdata_i[0]) |=> ovf_q);

    // R5
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(evt_hit));

    // R5
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_o) |-> $past(host_rd_i && fifo_sel));

    // R3
    masked_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o && evt_strobe_i && !evt_hit |=> !irq_o);

endmodule

bind evt_capture evt_capture_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .evt_strobe_i (evt_strobe_i),
    .host_wr_i    (host_wr_i),
    .host_rd_i    (host_rd_i),
    .host_addr_i  (host_addr_i),
    .host_wdata_i (host_wdata_i),
    .host_rdata_o (host_rdata_o),
    .irq_o        (irq_o),
    .evt_hit      (evt_hit),
    .q_full       (q_full),
    .ovf_q        (ovf_q)
);

// File: tb/evt_capture_tb.sv
module evt_capture_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam logic [9:0] FIFO_ADDR = 10'h200;
    localparam logic [9:0] STAT_ADDR = 10'h202;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_strobe_i = 1'b0;
    logic [7:0]  evt_code_i = '0;
    logic        host_wr_i = 1'b0;
    logic        host_rd_i = 1'b0;
    logic [9:0]  host_addr_i = '0;
    logic [15:0] host_wdata_i = '0;
    logic [15:0] host_rdata_o;
    logic        irq_o;
    logic [7:0]  irq_vec_o;

    int checks = 0;
    int fails  = 0;
    string cur_tag = "R1";

    logic [7:0] exp_q [$];
    logic       mask_m [256];
    logic       ovf_m = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    evt_capture u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .evt_strobe_i (evt_strobe_i),
        .evt_code_i   (evt_code_i),
        .host_wr_i    (host_wr_i),
        .host_rd_i    (host_rd_i),
        .host_addr_i  (host_addr_i),
        .host_wdata_i (host_wdata_i),
        .host_rdata_o (host_rdata_o),
        .irq_o        (irq_o),
        .irq_vec_o    (irq_vec_o)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    function automatic logic [9:0] mask_addr(input logic [7:0] code);
        return {1'b0, code, 1'b0};
    endfunction

    // Monitor: every FIFO read pops the scoreboard and compares the returned word.
    always @(posedge clk) begin
        if (rst_n && host_rd_i && host_addr_i == FIFO_ADDR) begin
            logic [15:0] e;
            e = (exp_q.size() > 0) ? {8'h00, exp_q.pop_front()} : 16'h0000;
            #3;
            chk(cur_tag, host_rdata_o, e);
        end
    end

    // Driver: one clocked step; the model is judged on its state before the edge.
    task automatic step(input logic stb, input logic [7:0] code, input logic wr,
                        input logic rd, input logic [9:0] addr, input logic [15:0] wd);
        logic acc, dropped;
        @(negedge clk);
        evt_strobe_i = stb; evt_code_i = code;
        host_wr_i = wr; host_rd_i = rd; host_addr_i = addr; host_wdata_i = wd;
        acc     = stb && mask_m[code] && (exp_q.size() < DEPTH);
        dropped = stb && mask_m[code] && (exp_q.size() >= DEPTH);
        @(posedge clk);
        #1;
        if (acc) exp_q.push_back(code);
        if (dropped) ovf_m = 1'b1;
        else if (wr && addr == STAT_ADDR && wd[0]) ovf_m = 1'b0;
        if (wr && !addr[9]) mask_m[addr[8:1]] = wd[0];
        evt_strobe_i = 1'b0; host_wr_i = 1'b0; host_rd_i = 1'b0;
    endtask

    task automatic send(input logic [7:0] code);
        step(1'b1, code, 1'b0, 1'b0, '0, '0);
    endtask

    task automatic set_mask(input logic [7:0] code, input logic [15:0] wd);
        step(1'b0, '0, 1'b1, 1'b0, mask_addr(code), wd);
    endtask

    task automatic rd_reg(input string tag, input logic [9:0] addr, input logic [15:0] expv);
        step(1'b0, '0, 1'b0, 1'b1, addr, '0);
        chk(tag, host_rdata_o, expv);
    endtask

    task automatic pop_fifo(input string tag);
        cur_tag = tag;
        step(1'b0, '0, 1'b0, 1'b1, FIFO_ADDR, '0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mask_m[i] = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        #1;
        chk("R1 irq", {15'b0, irq_o}, 16'h0000);
        chk("R1 vec", {8'h00, irq_vec_o}, 16'h0016);
        rd_reg("R1 status", STAT_ADDR, 16'h0000);
        rd_reg("R1 mask", mask_addr(8'h5A), 16'h0000);
        pop_fifo("R1 fifo");

        // R2 mask write and readback
        set_mask(8'h10, 16'h0001);
        set_mask(8'h20, 16'h0001);
        set_mask(8'hFF, 16'h0001);
        set_mask(8'h30, 16'hFFFE);
        rd_reg("R2 mask 0x10", mask_addr(8'h10), 16'h0001);
        rd_reg("R2 mask bit0 only", mask_addr(8'h30), 16'h0000);
        rd_reg("R2 mask 0xFF", mask_addr(8'hFF), 16'h0001);

        // R3 disabled code
        send(8'h33);
        chk("R3 irq stays low", {15'b0, irq_o}, 16'h0000);

        // R4/R5 enabled codes, ordering, interrupt level
        send(8'h10);
        chk("R5 irq rises", {15'b0, irq_o}, 16'h0001);
        send(8'h20);
        send(8'hFF);
        pop_fifo("R4 first");
        chk("R5 irq held", {15'b0, irq_o}, 16'h0001);
        pop_fifo("R4 second");
        pop_fifo("R4 third");
        chk("R5 irq falls", {15'b0, irq_o}, 16'h0000);

        // R6 empty read
        pop_fifo("R6 empty read");
        chk("R6 irq unchanged", {15'b0, irq_o}, 16'h0000);
        rd_reg("R6 status unchanged", STAT_ADDR, 16'h0000);

        // R7 overflow
        for (int i = 0; i < DEPTH; i++) set_mask(8'(i + 8'h80), 16'h0001);
        for (int i = 0; i < DEPTH; i++) send(8'(i + 8'h80));
        send(8'h10);
        rd_reg("R7 ovf set", STAT_ADDR, {15'b0, ovf_m});
        chk("R7 ovf model", {15'b0, ovf_m}, 16'h0001);
        // drop on full even with a simultaneous pop
        cur_tag = "R7 pop during drop";
        step(1'b1, 8'h20, 1'b0, 1'b1, FIFO_ADDR, '0);
        for (int i = 1; i < DEPTH; i++) pop_fifo("R7 order after drop");
        chk("R7 irq low after drain", {15'b0, irq_o}, 16'h0000);

        // R8 sticky flag and clear
        step(1'b0, '0, 1'b1, 1'b0, STAT_ADDR, 16'h0000);
        rd_reg("R8 write0 keeps", STAT_ADDR, 16'h0001);
        step(1'b0, '0, 1'b1, 1'b0, STAT_ADDR, 16'h0001);
        rd_reg("R8 cleared", STAT_ADDR, 16'h0000);

        // R9 simultaneous mask write and event use old mask
        step(1'b1, 8'h40, 1'b1, 1'b0, mask_addr(8'h40), 16'h0001);
        chk("R9 old zero", {15'b0, irq_o}, 16'h0000);
        step(1'b1, 8'h40, 1'b1, 1'b0, mask_addr(8'h40), 16'h0000);
        chk("R9 old one", {15'b0, irq_o}, 16'h0001);
        pop_fifo("R9 queued code");
        rd_reg("R9 mask now 0", mask_addr(8'h40), 16'h0000);

        // R10 push and pop together
        send(8'h10);
        cur_tag = "R10 pop head";
        step(1'b1, 8'h20, 1'b0, 1'b1, FIFO_ADDR, '0);
        chk("R10 irq", {15'b0, irq_o}, 16'h0001);
        pop_fifo("R10 pushed entry");
        cur_tag = "R10 empty pop with push";
        step(1'b1, 8'hFF, 1'b0, 1'b1, FIFO_ADDR, '0);
        chk("R10 push kept", {15'b0, irq_o}, 16'h0001);
        pop_fifo("R10 remaining");
        chk("R10 irq low", {15'b0, irq_o}, 16'h0000);

        repeat (2) @(posedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule